// File: doc/BRIEF.md
# Prefixed Opcode Page Sequencer

This block sits at the front of an 8-bit CPU decode path. It takes the opcode stream one byte at a time and follows the prefix bytes that select an instruction page. The pages are the base page, the bit-operation page, the extended page, the two index pages and the two indexed bit-operation pages. When the byte that ends an instruction's opcode arrives, the block issues one decoded record: the page, the final opcode byte, an address field and two flags. The flags mark the index form and an opcode that has no entry on the extended page.

For the indexed bit-operation form, a signed displacement byte comes before the final opcode byte. The block sign-extends that byte and adds it to the selected index register as soon as the byte arrives, so the effective address is ready before the final opcode is decoded.

The block also owns the 8-bit memory refresh register. Its low seven bits advance on every opcode fetch except the displacement byte and the final opcode of an indexed bit-operation. Its top bit never changes except through a direct load.

Top module: `pfx_decode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `r_value` becomes 0x00 and `dec_valid` becomes 0, and the next accepted byte is read as a base-page byte.
- R2: Each accepted fetch byte in the base, bit (0xCB), extended (0xED) and index (0xDD/0xFD) pages increments `r_value[6:0]` modulo 128 and keeps `r_value[7]`. Prefix bytes count as fetches.
- R3: After an index prefix and 0xCB, neither the displacement byte nor the final opcode byte changes `r_value`.
- R4: `r_wr` loads all 8 bits of `r_value` from `r_wdata` at the clock edge. A load takes priority over an increment in the same cycle.
- R5: In the base state, 0xCB selects the bit page, 0xED the extended page, 0xDD the IX page and 0xFD the IY page. In the index state, another 0xDD or 0xFD re-selects the index register, and 0xED drops the index and selects the extended page.
- R6: An index prefix followed by 0xCB makes the next byte a displacement and the byte after it the final opcode. The address field is the index register value at the displacement byte plus the sign-extended displacement, modulo 65536.
- R7: The record is issued with `dec_valid` high for exactly the one cycle after the final byte is accepted. `dec_page` is coded 0 base, 1 bit, 2 extended, 3 IX, 4 IY, 5 IX-bit and 6 IY-bit. `dec_opcode` is the final byte.
- R8: `dec_addr` is the index register value on pages 3 and 4, the effective address on pages 5 and 6, and 0 elsewhere. `dec_indexed` is high exactly for pages 3 to 6.
- R9: On page 2, opcodes with bits 7:6 = 01, or with bits 7:5 = 101 and bit 2 = 0, are defined. Every other page-2 opcode sets `dec_undef`. No other page sets it.
- R10: After each record the next accepted byte is read in the base state.
- R11: A cycle with `byte_valid` low changes neither the page state nor `r_value`, unless `r_wr` is high, and issues no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Opcode-stream byte present this cycle |
| byte_in | input | 8 | Opcode-stream byte |
| ix_val | input | 16 | Current IX index register |
| iy_val | input | 16 | Current IY index register |
| r_wr | input | 1 | Load strobe for the refresh register |
| r_wdata | input | 8 | Value to load into the refresh register |
| r_value | output | 8 | Refresh register |
| dec_valid | output | 1 | Decoded record valid (one-cycle pulse) |
| dec_page | output | 3 | Page code of the record |
| dec_opcode | output | 8 | Final opcode byte |
| dec_addr | output | 16 | Index or effective address, else 0 |
| dec_indexed | output | 1 | Record uses the index form |
| dec_undef | output | 1 | Opcode has no entry on the extended page |

## Verification
The hardest case to reach is the four-byte indexed bit-operation, because the sequence has to go untouched through two prefix states and the displacement state. The refresh register has to be watched at both of the non-counting bytes. Random byte streams are weighted heavily toward the prefix values 0xDD, 0xFD, 0xCB and 0xED, so chains such as DD FD CB d op and DD ED op come up often. Directed sequences add the displacement extremes at address wrap points and a refresh load in the same cycle as a counting fetch.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [2:0] {
    PG_BASE  = 3'd0,
    PG_BIT   = 3'd1,
    PG_EXT   = 3'd2,
    PG_IX    = 3'd3,
    PG_IY    = 3'd4,
    PG_IXBIT = 3'd5,
    PG_IYBIT = 3'd6
  } page_e;

  typedef enum logic [2:0] {
    ST_OPEN,
    ST_BIT,
    ST_EXT,
    ST_IDX,
    ST_DISP,
    ST_XOP
  } seq_e;

  localparam logic [7:0] BYTE_BIT = 8'hCB;
  localparam logic [7:0] BYTE_EXT = 8'hED;
  localparam logic [7:0] BYTE_IX  = 8'hDD;
  localparam logic [7:0] BYTE_IY  = 8'hFD;

  // Extended page: defined entries are the 0x40..0x7F block and the
  // block-transfer group in 0xA0..0xBF with bit 2 clear.
  function automatic logic ext_defined(input logic [7:0] op);
    return (op[7:6] == 2'b01) || (op[7:5] == 3'b101 && !op[2]);
  endfunction

endpackage

// File: rtl/pfx_refresh_ctr.sv
module pfx_refresh_ctr #(
  parameter int RC_W = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bump,
  input  logic          ld,
  input  logic [RC_W:0] ld_val,
  output logic [RC_W:0] r_q
);
  localparam logic [RC_W-1:0] CNT_ONE = {{(RC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q <= '0;
    end else if (ld) begin
      r_q <= ld_val;
    end else if (bump) begin
      r_q <= {r_q[RC_W], r_q[RC_W-1:0] + CNT_ONE};
    end
  end
endmodule

// File: rtl/pfx_ea_calc.sv
module pfx_ea_calc #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  assign ea = base + disp_ext;
endmodule

// File: rtl/pfx_page_fsm.sv
module pfx_page_fsm
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       bump,
  output logic       fin,
  output page_e      fin_page,
  output logic       cap_disp,
  output logic       sel_iy
);
  seq_e st_q, st_d;
  logic sel_q, sel_d;

  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    bump     = 1'b0;
    fin      = 1'b0;
    fin_page = PG_BASE;
    cap_disp = 1'b0;
    if (byte_valid) begin
      unique case (st_q)
        ST_OPEN: begin
          bump = 1'b1;
          if (byte_in == BYTE_BIT) begin
            st_d = ST_BIT;
          end else if (byte_in == BYTE_EXT) begin
            st_d = ST_EXT;
          end else if (byte_in == BYTE_IX || byte_in == BYTE_IY) begin
            st_d  = ST_IDX;
            sel_d = (byte_in == BYTE_IY);
          end else begin
            fin      = 1'b1;
            fin_page = PG_BASE;
          end
        end
        ST_BIT: begin
          bump     = 1'b1;
          fin      = 1'b1;
          fin_page = PG_BIT;
          st_d     = ST_OPEN;
        end
        ST_EXT: begin
          bump     = 1'b1;
          fin      = 1'b1;
          fin_page = PG_EXT;
          st_d     = ST_OPEN;
        end
        ST_IDX: begin
          bump = 1'b1;
          if (byte_in == BYTE_BIT) begin
            st_d = ST_DISP;
          end else if (byte_in == BYTE_EXT) begin
            st_d = ST_EXT;
          end else if (byte_in == BYTE_IX || byte_in == BYTE_IY) begin
            sel_d = (byte_in == BYTE_IY);
          end else begin
            fin      = 1'b1;
            fin_page = sel_q ? PG_IY : PG_IX;
            st_d     = ST_OPEN;
          end
        end
        ST_DISP: begin
          cap_disp = 1'b1;
          st_d     = ST_XOP;
        end
        ST_XOP: begin
          fin      = 1'b1;
          fin_page = sel_q ? PG_IYBIT : PG_IXBIT;
          st_d     = ST_OPEN;
        end
        default: st_d = ST_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OPEN;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
    end
  end

  assign sel_iy = sel_q;
endmodule

// File: rtl/pfx_decode_seq.sv
module pfx_decode_seq
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RC_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  input  logic [ADDR_W-1:0] ix_val,
  input  logic [ADDR_W-1:0] iy_val,
  input  logic              r_wr,
  input  logic [RC_W:0]     r_wdata,
  output logic [RC_W:0]     r_value,
  output logic              dec_valid,
  output logic [2:0]        dec_page,
  output logic [7:0]        dec_opcode,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              dec_indexed,
  output logic              dec_undef
);
  logic        bump, fin, cap_disp, sel_iy;
  page_e       fin_page;
  logic [ADDR_W-1:0] idx_now, ea_new, ea_q, addr_d;

  pfx_page_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .byte_valid(byte_valid),
    .byte_in   (byte_in),
    .bump      (bump),
    .fin       (fin),
    .fin_page  (fin_page),
    .cap_disp  (cap_disp),
    .sel_iy    (sel_iy)
  );

  pfx_refresh_ctr #(.RC_W(RC_W)) u_rctr (
    .clk   (clk),
    .rst   (rst),
    .bump  (bump),
    .ld    (r_wr),
    .ld_val(r_wdata),
    .r_q   (r_value)
  );

  assign idx_now = sel_iy ? iy_val : ix_val;

  pfx_ea_calc #(.ADDR_W(ADDR_W), .DISP_W(8)) u_ea (
    .base(idx_now),
    .disp(byte_in),
    .ea  (ea_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_q <= '0;
    end else if (cap_disp) begin
      ea_q <= ea_new;
    end
  end

  always_comb begin
    unique case (fin_page)
      PG_IX, PG_IY:       addr_d = idx_now;
      PG_IXBIT, PG_IYBIT: addr_d = ea_q;
      default:            addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      dec_page    <= PG_BASE;
      dec_opcode  <= '0;
      dec_addr    <= '0;
      dec_indexed <= 1'b0;
      dec_undef   <= 1'b0;
    end else begin
      dec_valid <= fin;
      if (fin) begin
        dec_page    <= fin_page;
        dec_opcode  <= byte_in;
        dec_addr    <= addr_d;
        dec_indexed <= (fin_page >= PG_IX);
        dec_undef   <= (fin_page == PG_EXT) && !ext_defined(byte_in);
      end
    end
  end
endmodule

// File: rtl/pfx_decode_seq_chk.sv
module pfx_decode_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int RC_W   = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_valid,
  input logic          r_wr,
  input logic [RC_W:0] r_value,
  input logic          dec_valid,
  input logic [2:0]    dec_page,
  input logic          dec_indexed,
  input logic          dec_undef
);
  localparam logic [RC_W-1:0] ONE = {{(RC_W-1){1'b0}}, 1'b1};

  p_top_bit_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(r_wr) && !$past(rst)) |-> (r_value[RC_W] == $past(r_value[RC_W])));

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(r_wr) && !$past(rst)) |->
      (r_value[RC_W-1:0] == $past(r_value[RC_W-1:0]) ||
       r_value[RC_W-1:0] == $past(r_value[RC_W-1:0]) + ONE));

  p_bitidx_no_count_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_page >= 3'd5 && !$past(r_wr) && !$past(rst)) |-> $stable(r_value));

  p_record_needs_byte_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !$past(rst)) |-> $past(byte_valid));

  p_idle_no_count_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(byte_valid) && !$past(r_wr) && !$past(rst)) |-> ($stable(r_value) && !dec_valid));

  p_index_pages_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_indexed == (dec_page >= 3'd3)));

  p_undef_ext_only_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_undef) |-> (dec_page == 3'd2));

  p_page_code_range_r7: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_page <= 3'd6));
endmodule

bind pfx_decode_seq pfx_decode_seq_chk #(.ADDR_W(ADDR_W), .RC_W(RC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_valid (byte_valid),
  .r_wr       (r_wr),
  .r_value    (r_value),
  .dec_valid  (dec_valid),
  .dec_page   (dec_page),
  .dec_indexed(dec_indexed),
  .dec_undef  (dec_undef)
);

// File: tb/sim_pfx_decode_seq.sv
`timescale 1ns/1ps
module sim_pfx_decode_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [15:0] ix_val = 16'h0000;
  logic [15:0] iy_val = 16'h0000;
  logic        r_wr = 1'b0;
  logic [7:0]  r_wdata = 8'h00;
  logic [7:0]  r_value;
  logic        dec_valid;
  logic [2:0]  dec_page;
  logic [7:0]  dec_opcode;
  logic [15:0] dec_addr;
  logic        dec_indexed;
  logic        dec_undef;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfx_decode_seq u0 (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .ix_val(ix_val), .iy_val(iy_val), .r_wr(r_wr), .r_wdata(r_wdata),
    .r_value(r_value), .dec_valid(dec_valid), .dec_page(dec_page),
    .dec_opcode(dec_opcode), .dec_addr(dec_addr), .dec_indexed(dec_indexed),
    .dec_undef(dec_undef)
  );

  // reference state: 0 open, 1 bit, 2 ext, 3 idx, 4 disp, 5 final
  int         m_st = 0;
  bit         m_iy = 0;
  logic [7:0]  m_r = 8'h00;
  logic [15:0] m_ea = 16'h0000;

  function automatic bit ext_ok(input logic [7:0] op);
    return (op[7:6] == 2'b01) || (op[7:5] == 3'b101 && op[2] == 1'b0);
  endfunction

  function automatic logic [15:0] disp_add(input logic [15:0] b, input logic [7:0] d);
    return b + {{8{d[7]}}, d};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] b, input bit w, input logic [7:0] wd);
    bit ev = 0; bit bmp = 0; int pg = 0; logic [15:0] ea_addr = 16'h0;
    logic [15:0] idx = m_iy ? iy_val : ix_val;
    string rq;
    if (v) begin
      case (m_st)
        0: begin
          bmp = 1;
          if (b == 8'hCB) m_st = 1;
          else if (b == 8'hED) m_st = 2;
          else if (b == 8'hDD || b == 8'hFD) begin m_st = 3; m_iy = (b == 8'hFD); end
          else begin ev = 1; pg = 0; end
        end
        1: begin bmp = 1; ev = 1; pg = 1; m_st = 0; end
        2: begin bmp = 1; ev = 1; pg = 2; m_st = 0; end
        3: begin
          bmp = 1;
          if (b == 8'hCB) m_st = 4;
          else if (b == 8'hED) m_st = 2;
          else if (b == 8'hDD || b == 8'hFD) m_iy = (b == 8'hFD);
          else begin ev = 1; pg = m_iy ? 4 : 3; ea_addr = idx; m_st = 0; end
        end
        4: begin m_ea = disp_add(idx, b); m_st = 5; end
        default: begin ev = 1; pg = m_iy ? 6 : 5; ea_addr = m_ea; m_st = 0; end
      endcase
    end
    if (w) m_r = wd;
    else if (bmp) m_r = {m_r[7], m_r[6:0] + 7'd1};
    byte_valid = v; byte_in = b; r_wr = w; r_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    byte_valid = 0; r_wr = 0;
    rq = !v ? "R11" : (pg >= 5 ? "R6" : (pg == 2 ? "R9" : "R7"));
    check(dec_valid == ev, rq, "dec_valid", 32'(dec_valid), 32'(ev));
    check(r_value == m_r, w ? "R4" : (bmp ? "R2" : "R3"), "r_value", 32'(r_value), 32'(m_r));
    if (ev && dec_valid) begin
      check(dec_page == 3'(pg), rq, "dec_page", 32'(dec_page), 32'(pg));
      check(dec_opcode == b, "R7", "dec_opcode", 32'(dec_opcode), 32'(b));
      check(dec_addr == ea_addr, (pg >= 5) ? "R6" : "R8", "dec_addr", 32'(dec_addr), 32'(ea_addr));
      check(dec_indexed == (pg >= 3), "R8", "dec_indexed", 32'(dec_indexed), 32'(pg >= 3));
      check(dec_undef == (pg == 2 && !ext_ok(b)), "R9", "dec_undef",
            32'(dec_undef), 32'(pg == 2 && !ext_ok(b)));
    end
  endtask

  task automatic feed(input logic [7:0] b);
    step(1'b1, b, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 0;
    check(r_value == 8'h00 && dec_valid == 1'b0, "R1", "reset state",
          32'({dec_valid, r_value}), 32'h0);
    // R1: first byte after reset is base page
    feed(8'h00);

    // R5 prefix selection, R10 return to base
    feed(8'hCB); feed(8'h11);
    feed(8'hED); feed(8'h44);
    ix_val = 16'h1234; iy_val = 16'hABCD;
    feed(8'hDD); feed(8'h21);
    feed(8'h21);                               // R10 base again
    feed(8'hDD); feed(8'hFD); feed(8'h09);     // R5 reselect to IY
    feed(8'hFD); feed(8'hED); feed(8'h45);     // R5 index dropped
    // R9 undefined entries on extended page
    feed(8'hED); feed(8'h00);
    feed(8'hED); feed(8'hA4);
    feed(8'hED); feed(8'hB8);

    // R6 wrap cases
    ix_val = 16'hFFF0;
    feed(8'hDD); feed(8'hCB); feed(8'h20); feed(8'h46);
    iy_val = 16'h0005;
    feed(8'hFD); feed(8'hCB); feed(8'h80); feed(8'hC6);
    // R6 index value captured at displacement byte
    ix_val = 16'h4000;
    feed(8'hDD); feed(8'hCB); feed(8'h7F);
    ix_val = 16'h9999;
    feed(8'h06);

    // R4 load priority and R2 wrap with top bit kept
    step(1'b1, 8'h00, 1'b1, 8'hFF);
    feed(8'h00);                                // 0xFF -> 0x80
    step(1'b0, 8'h00, 1'b1, 8'h7F);
    feed(8'h00);                                // 0x7F -> 0x00
    // R3 load during displacement, final still holds
    feed(8'hFD); feed(8'hCB);
    step(1'b1, 8'h01, 1'b1, 8'h55);
    feed(8'h0E);
    // R11 idle cycles mid-sequence
    feed(8'hDD);
    step(1'b0, 8'hCB, 1'b0, 8'h00);
    feed(8'h7E);

    // random weighted stream
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] rb;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0: rb = 8'hCB;
        1: rb = 8'hED;
        2: rb = 8'hDD;
        3: rb = 8'hFD;
        default: rb = 8'($urandom);
      endcase
      if ($urandom_range(0, 63) == 0) begin
        ix_val = 16'($urandom); iy_val = 16'($urandom);
      end
      step($urandom_range(0, 7) != 0, rb, $urandom_range(0, 31) == 0, 8'($urandom));
    end
    finish_run();
  end
endmodule